// File: doc/BRIEF.md
# Value-Added Update Engine

This engine recomputes a signed value figure for every line age of a cache replacement scheme. It reads per-age hit and eviction counters from a 16-bit counter memory. It walks the ages from the oldest to the youngest and writes one 32-bit result per age into a value memory. The value of a line at age `a` is the hit reward it can still expect, less the cache share it occupies while it waits. That share is its expected remaining residency multiplied by the per-line hit rate. The total is then averaged over every future event at or beyond age `a`.

All arithmetic goes through one shared adder and a barrel shifter. Multiplication and division are iterative, one adder step per cycle. The engine is therefore slow, but its logic is small. A host pulses `start`, supplies a cache hit rate and the cache size as a power of two, and waits for `done`.

Top module: `valadd_update_engine`

## Requirements
- R1: After reset, `busy`, `done` and `val_we` are all low.
- R2: A `start` pulse is accepted only while the engine is idle. A `start` that arrives while `busy` is high changes neither the written values nor the timing.
- R3: Exactly one value is written per age. The writes run from address AGES-1 down to address 0, in that order, and `val_we` is only ever high while `busy` is high.
- R4: A counter read address is {kind, age}, where the MSB is the kind (0 = hit counter, 1 = eviction counter). Read data is expected one cycle after the address.
- R5: The per-line rate is the 16.16 unsigned `hit_rate` shifted right by `lines_log2`, truncating, and captured at start.
- R6: Going from the oldest age down, the engine keeps three tail sums. H(a) is the sum of hits at ages >= a. N(a) is the sum of hits plus evictions at ages >= a. T(a) = T(a+1) + N(a+1) is the total remaining residency, with T(AGES-1) = 0. Let num = (H<<16) - rate*T, taken modulo 2^32 as a signed 16.16 value. The written value is num / N in signed 16.16.
- R7: When N(a) is zero, the value written is 0. No fault is raised.
- R8: Each age with N > 0 takes 101 cycles: 6 for reading and accumulating, 33 for the multiply, 57 for the divide, and 5 more. Each age with N = 0 takes 7 cycles. `done` comes exactly 1 + (sum of the per-age cycles) cycles after the clock edge that accepts `start`.
- R9: `busy` stays high through the last write. `done` is high for exactly one cycle in the next cycle and is never high together with `busy`.
- R10: The quotient is rounded to the nearest 2^-16, with halves rounded away from zero. A negative value is written in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an update when the engine is idle |
| hit_rate | input | 32 | Cache hit rate, unsigned 16.16 |
| lines_log2 | input | 5 | log2 of the cache size in lines |
| cnt_raddr | output | AW+1 | Counter read address {kind, age} |
| cnt_rdata | input | 16 | Counter read data, one cycle after the address |
| val_we | output | 1 | Value memory write enable |
| val_waddr | output | AW | Value memory write address (age) |
| val_wdata | output | 32 | Value, signed 16.16 |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
On every cycle, the assertions check the handshake shape. They check that `done` is a single-cycle pulse that never overlaps `busy`, that writes happen only while busy, that the write to age 0 is followed at once by `done`, and that `busy` cannot drop in the middle of a run. Only the bench's scenarios can show the arithmetic. These cover the worked rate example, negative eviction values, rounding at exact halves, empty tails, truncation of the rate shift, and the exact cycle cost of each age. A behavioural model in the bench predicts every write's cycle, address and value.

// File: rtl/valadd_pkg.sv
package valadd_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_RDH, S_RDE, S_ACCT, S_ACCH, S_ACCN1, S_ACCN2,
        S_MUL, S_SUBN, S_ABS, S_DIV, S_RND, S_SGN, S_WR, S_DONE
    } upd_state_e;
endpackage

// File: rtl/upd_adder.sv
module upd_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    // The only adder in the engine; subtraction is done by inverting b and adding a carry-in.
    assign y = a + (sub ? ~b : b) + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/upd_shift.sv
module upd_shift #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  dout
);
    always_comb begin
        if (left) dout = din << amt;
        else      dout = din >> amt;
    end
endmodule

// File: rtl/valadd_update_engine.sv
module valadd_update_engine
    import valadd_pkg::*;
#(
    parameter int AGES  = 16,
    parameter int CNT_W = 16,
    parameter int VAL_W = 32,
    parameter int FRAC  = 16,
    parameter int GUARD = 24,
    parameter int AW    = $clog2(AGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VAL_W-1:0] hit_rate,
    input  logic [4:0]       lines_log2,
    output logic [AW:0]      cnt_raddr,
    input  logic [CNT_W-1:0] cnt_rdata,
    output logic             val_we,
    output logic [AW-1:0]    val_waddr,
    output logic [VAL_W-1:0] val_wdata,
    output logic             busy,
    output logic             done
);
    localparam int DIV_ITERS = VAL_W + GUARD;
    localparam int ADD_W     = DIV_ITERS + 1;
    localparam int CYC_W     = $clog2(DIV_ITERS + 1);
    localparam int SHA_W     = $clog2(VAL_W);

    typedef struct packed {
        upd_state_e           st;
        logic [AW-1:0]        age;
        logic [CYC_W-1:0]     cnt;
        logic [VAL_W-1:0]     rate;
        logic [VAL_W-1:0]     tsum;
        logic [VAL_W-1:0]     hsum;
        logic [VAL_W-1:0]     nsum;
        logic [CNT_W-1:0]     hcur;
        logic [CNT_W-1:0]     ecur;
        logic [VAL_W-1:0]     acc;
        logic [VAL_W-1:0]     mq;
        logic [VAL_W-1:0]     md;
        logic [VAL_W:0]       rem;
        logic [DIV_ITERS-1:0] dd;
        logic                 neg;
    } eng_t;

    eng_t r_q, r_d;

    logic [ADD_W-1:0] alu_a, alu_b, alu_y;
    logic             alu_sub;
    logic [VAL_W-1:0] sh_in, sh_out;
    logic [SHA_W-1:0] sh_amt;
    logic             sh_left;

    upd_adder #(.W(ADD_W)) u_add (.a(alu_a), .b(alu_b), .sub(alu_sub), .y(alu_y));
    upd_shift #(.W(VAL_W), .SW(SHA_W)) u_sh (.din(sh_in), .amt(sh_amt), .left(sh_left), .dout(sh_out));

    // Operand steering for the shared adder and the shifter.
    always_comb begin
        alu_a   = '0;
        alu_b   = '0;
        alu_sub = 1'b0;
        sh_in   = r_q.md;
        sh_amt  = SHA_W'(1);
        sh_left = 1'b1;
        unique case (r_q.st)
            S_SETUP: begin sh_in = hit_rate; sh_amt = SHA_W'(lines_log2); sh_left = 1'b0; end
            S_ACCT:  begin alu_a = ADD_W'(r_q.tsum); alu_b = ADD_W'(r_q.nsum); end
            S_ACCH:  begin alu_a = ADD_W'(r_q.hsum); alu_b = ADD_W'(r_q.hcur); end
            S_ACCN1: begin alu_a = ADD_W'(r_q.nsum); alu_b = ADD_W'(r_q.hcur); end
            S_ACCN2: begin alu_a = ADD_W'(r_q.nsum); alu_b = ADD_W'(r_q.ecur); end
            S_MUL:   begin alu_a = ADD_W'(r_q.acc);  alu_b = ADD_W'(r_q.md); end
            S_SUBN:  begin
                sh_in = r_q.hsum; sh_amt = SHA_W'(FRAC);
                alu_a = ADD_W'(sh_out); alu_b = ADD_W'(r_q.acc); alu_sub = 1'b1;
            end
            S_ABS:   begin alu_b = ADD_W'(r_q.acc); alu_sub = r_q.acc[VAL_W-1]; end
            S_DIV:   begin
                alu_a = ADD_W'({r_q.rem[VAL_W-1:0], r_q.dd[DIV_ITERS-1]});
                alu_b = ADD_W'(r_q.nsum); alu_sub = 1'b1;
            end
            S_RND:   begin alu_a = ADD_W'(r_q.dd); alu_b = ADD_W'(1) << (GUARD - 1); end
            S_SGN:   begin alu_b = ADD_W'(r_q.acc); alu_sub = r_q.neg; end
            default: ;
        endcase
    end

    // Sequencer: one adder operation per cycle.
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE:  if (start) r_d.st = S_SETUP;
            S_SETUP: begin
                r_d.rate = sh_out;
                r_d.tsum = '0; r_d.hsum = '0; r_d.nsum = '0;
                r_d.age  = AW'(AGES - 1);
                r_d.st   = S_RDH;
            end
            S_RDH:   r_d.st = S_RDE;
            S_RDE:   begin r_d.hcur = cnt_rdata; r_d.st = S_ACCT; end
            S_ACCT:  begin r_d.ecur = cnt_rdata; r_d.tsum = alu_y[VAL_W-1:0]; r_d.st = S_ACCH; end
            S_ACCH:  begin r_d.hsum = alu_y[VAL_W-1:0]; r_d.st = S_ACCN1; end
            S_ACCN1: begin r_d.nsum = alu_y[VAL_W-1:0]; r_d.st = S_ACCN2; end
            S_ACCN2: begin
                r_d.nsum = alu_y[VAL_W-1:0];
                r_d.cnt  = '0;
                if (alu_y[VAL_W-1:0] == '0) begin
                    r_d.acc = '0;
                    r_d.st  = S_WR;
                end else begin
                    r_d.st  = S_MUL;
                end
            end
            S_MUL: begin
                if (r_q.cnt == '0) begin
                    r_d.acc = '0; r_d.mq = r_q.tsum; r_d.md = r_q.rate;
                    r_d.cnt = CYC_W'(1);
                end else begin
                    if (r_q.mq[0]) r_d.acc = alu_y[VAL_W-1:0];
                    r_d.mq = r_q.mq >> 1;
                    r_d.md = sh_out;
                    if (r_q.cnt == CYC_W'(VAL_W)) r_d.st = S_SUBN;
                    else r_d.cnt = r_q.cnt + CYC_W'(1);
                end
            end
            S_SUBN:  begin r_d.acc = alu_y[VAL_W-1:0]; r_d.st = S_ABS; end
            S_ABS:   begin
                r_d.neg = r_q.acc[VAL_W-1];
                r_d.acc = alu_y[VAL_W-1:0];
                r_d.cnt = '0;
                r_d.st  = S_DIV;
            end
            S_DIV: begin
                if (r_q.cnt == '0) begin
                    r_d.rem = '0;
                    r_d.dd  = {r_q.acc, {GUARD{1'b0}}};
                    r_d.cnt = CYC_W'(1);
                end else begin
                    if (alu_y[ADD_W-1]) r_d.rem = {r_q.rem[VAL_W-1:0], r_q.dd[DIV_ITERS-1]};
                    else                r_d.rem = alu_y[VAL_W:0];
                    r_d.dd = {r_q.dd[DIV_ITERS-2:0], ~alu_y[ADD_W-1]};
                    if (r_q.cnt == CYC_W'(DIV_ITERS)) r_d.st = S_RND;
                    else r_d.cnt = r_q.cnt + CYC_W'(1);
                end
            end
            S_RND:   begin r_d.acc = alu_y[GUARD +: VAL_W]; r_d.st = S_SGN; end
            S_SGN:   begin r_d.acc = alu_y[VAL_W-1:0]; r_d.st = S_WR; end
            S_WR: begin
                if (r_q.age == '0) r_d.st = S_DONE;
                else begin
                    r_d.age = r_q.age - AW'(1);
                    r_d.st  = S_RDH;
                end
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_raddr = {(r_q.st == S_RDE), r_q.age};
    assign val_we    = (r_q.st == S_WR);
    assign val_waddr = r_q.age;
    assign val_wdata = r_q.acc;
    assign busy      = (r_q.st != S_IDLE) && (r_q.st != S_DONE);
    assign done      = (r_q.st == S_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
    // R3
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n) val_we |-> busy);
    // R9
    last_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && val_waddr == '0) |=> done);
    // R2
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(val_we && val_waddr == '0)) |=> busy);
endmodule

// File: tb/valadd_update_engine_tb_top.sv
module valadd_update_engine_tb_top;
    localparam int AGES = 16;
    localparam int AW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] hit_rate = '0;
    logic [4:0]  lines_log2 = '0;
    logic [AW:0] cnt_raddr;
    logic [15:0] cnt_rdata = '0;
    logic        val_we;
    logic [AW-1:0] val_waddr;
    logic [31:0] val_wdata;
    logic        busy, done;

    int hits [AGES];
    int evs  [AGES];
    longint exp_val [AGES];
    longint exp_rel [AGES];
    longint total_cyc;
    int checks = 0;
    int failures = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // R4: counter memory with {kind, age} addressing and one-cycle read latency
    always @(posedge clk)
        cnt_rdata <= cnt_raddr[AW] ? 16'(evs[cnt_raddr[AW-1:0]]) : 16'(hits[cnt_raddr[AW-1:0]]);

    valadd_update_engine #(.AGES(AGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .hit_rate(hit_rate),
        .lines_log2(lines_log2), .cnt_raddr(cnt_raddr), .cnt_rdata(cnt_rdata),
        .val_we(val_we), .val_waddr(val_waddr), .val_wdata(val_wdata),
        .busy(busy), .done(done));

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Behavioural reference: tail sums walked with plain integers.
    task automatic model(input longint rate_in, input int lg);
        longint mask = 64'hFFFF_FFFF;
        longint rate = rate_in >> lg;
        longint t = 0, h = 0, n = 0, rel = 0;
        for (int a = AGES - 1; a >= 0; a--) begin
            longint prod, num, mag, r;
            bit neg;
            t = t + n;
            h = h + hits[a];
            n = n + hits[a] + evs[a];
            if (n == 0) begin
                exp_val[a] = 0;
                rel = rel + 7;
            end else begin
                prod = (rate * t) & mask;
                num  = ((h << 16) - prod) & mask;
                neg  = num[31];
                mag  = neg ? ((64'h1_0000_0000 - num) & mask) : num;
                if (neg && mag == 0) mag = 64'h8000_0000;
                r    = (2 * mag + n) / (2 * n);
                exp_val[a] = neg ? ((64'h1_0000_0000 - r) & mask) : (r & mask);
                rel = rel + 101;
            end
            exp_rel[a] = rel;
        end
        total_cyc = rel;
    endtask

    // Runs one update and compares every clock against the model.
    task automatic run_case(input longint rate_in, input int lg, input int mid_start, input string tag);
        int next_age = AGES - 1;
        longint done_rel = -1;
        model(rate_in, lg);
        hit_rate   = 32'(rate_in);
        lines_log2 = 5'(lg);
        @(negedge clk);
        start = 1'b1;
        for (longint rel = 0; rel <= total_cyc + 2; rel++) begin
            bit exp_busy, exp_done, exp_we;
            @(negedge clk);
            start = (mid_start > 0 && rel == mid_start) ? 1'b1 : 1'b0;
            exp_busy = (rel <= total_cyc);
            exp_done = (rel == total_cyc + 1);
            exp_we   = (next_age >= 0) && (exp_rel[next_age] == rel);
            // R8 R9: busy and done follow the predicted schedule
            chk(busy == exp_busy, {"R9 busy ", tag}, busy, exp_busy);
            chk(done == exp_done, {"R8 done timing ", tag}, done, exp_done);
            if (done) done_rel = rel;
            // R3: one write per age in descending order
            chk(val_we == exp_we, {"R3 write enable ", tag}, val_we, exp_we);
            if (exp_we && val_we) begin
                chk(val_waddr == AW'(next_age), {"R3 write address ", tag}, val_waddr, next_age);
                // R6 R7 R10: written value matches the reference arithmetic
                chk(longint'(val_wdata) == exp_val[next_age], {"R6 value ", tag},
                    longint'(val_wdata), exp_val[next_age]);
                next_age--;
            end
        end
        chk(done_rel == total_cyc + 1, {"R8 done cycle ", tag}, done_rel, total_cyc + 1);
        chk(next_age == -1, {"R3 all ages written ", tag}, next_age, -1);
    endtask

    task automatic clear_counts();
        for (int i = 0; i < AGES; i++) begin hits[i] = 0; evs[i] = 0; end
    endtask

    initial begin
        clear_counts();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(val_we == 1'b0, "R1 write enable", val_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R5: 40% hit rate over 16 lines, single hit ten ages out (0.75 at age 0)
        hits[10] = 1;
        run_case(26214, 4, 0, "worked hit");
        // R6 R10: lone eviction at the oldest age gives negative values
        clear_counts(); evs[15] = 1;
        run_case(26214, 4, 0, "eviction");
        // R7 R8: empty tails everywhere, every value zero, 7 cycles per age
        clear_counts();
        run_case(26214, 4, 0, "all zero R7");
        // R10: exact halves round away from zero, positive then negative
        clear_counts(); hits[1] = 1; evs[0] = 1;
        run_case(1, 0, 0, "half up R10");
        clear_counts(); evs[1] = 1; evs[0] = 1;
        run_case(1, 0, 0, "half down R10");
        // R5: truncating shift of the rate
        clear_counts(); hits[3] = 5; evs[7] = 2; hits[12] = 9;
        run_case(32'h0003_0007, 2, 0, "rate shift R5");
        // R2: mixed counters, with a second start pulse mid-run that must be ignored
        clear_counts();
        begin
            int s = 7;
            for (int i = 0; i < AGES; i++) begin
                s = (s * 1103 + 12345) % 65521;
                hits[i] = (i % 5 == 2) ? 0 : s % 300;
                s = (s * 1103 + 12345) % 65521;
                evs[i]  = s % 500;
            end
        end
        run_case(39322, 3, 50, "mixed with restart R2");
        // R4 R6: large counts exercise the wide tail sums
        clear_counts();
        for (int i = 0; i < AGES; i++) begin hits[i] = 65535 - i; evs[i] = 1000 * i; end
        run_case(6554, 6, 0, "large R4");

        finish_run();
    end
endmodule